// File: doc/BRIEF.md
# Serial Bus Host Transaction Sequencer

This block is the host end of a byte-serial peripheral bus. It does not drive the bus wires itself. An external transceiver does the bit timing and exchanges one byte at a time with the host over a shift-register handshake. The host tells the transceiver which part of a transaction comes next by driving a 2-bit phase code. The transceiver answers each byte with a shift-complete pulse, the received byte, and an active-low attention line.

A single-entry request port accepts one command byte, up to `MAXD` data bytes and a flag saying whether a reply is expected. The sequencer sends the request and steps the phase code once per byte. Reply bytes are collected into a 16-entry buffer that is read through a registered port. Two kinds of packets arrive without a request:

- unsolicited packets that come in while the bus is idle;
- autopoll replies that pre-empt a command, in which case the command is retried afterwards.

A poll-kick input queues a Talk-register-0 poll ahead of any waiting request. The polled address is chosen from a 16-bit device mask.

Top module: `sbh_seq`

## Requirements
- R1: After reset, the phase output is idle (11), shift direction is input, `req_ready` is 1, `done` and `overflow` are 0, and the three command records hold 0x00 (last command), 0x0C (last Talk) and 0x0C (last poll).
- R2: Starting a transaction sets the direction to output, places the command byte on `xc_tx` and drives phase 00 (command). The phase enters 00 only from idle.
- R3: If a command is accepted (attention deasserted at a shift-complete in phase 00), has no data bytes and expects no reply, the phase returns to 11 and `done` pulses with `reply_len` 0.
- R4: Data bytes go out in order, byte 0 taken from `req_data[7:0]`. The first data byte is sent in phase 01 (even). Each later byte inverts both phase bits, so the phase alternates 01 and 10.
- R5: During a reply, each shift-complete with attention asserted (low) stores `xc_rx` and inverts the phase. A shift-complete with attention deasserted ends the packet: that byte is discarded, the phase goes to 11, and `done` pulses with the byte count.
- R6: Attention asserted at the shift-complete of the command byte starts an autopoll reply. Direction switches to input, the phase goes to 01, and nothing is recorded. The interrupted request is kept and is issued again once that reply ends.
- R7: In idle, a shift-complete with attention asserted stores the byte as reply byte 0 and moves the phase to 01. With attention deasserted it is a timeout: `done` pulses with length 0 and the phase stays 11.
- R8: Each accepted command is recorded in `last_cmd`. A command is a Talk when bits 3:2 are 11; Talks are also recorded in `last_talk`. A Talk whose register field (bits 1:0) is 00 is also recorded in `last_poll`.
- R9: A poll is the command {address, 4'b1100}. The address in bits 7:4 of `last_poll` is reused, unless either `srq` is high and `last_cmd` equals `last_poll`, or that address bit is clear in `ap_mask`. In either of those cases the next higher set address is taken, wrapping from 15 to 0.
- R10: A poll kick while `ap_mask` is zero has no effect: no transaction starts.
- R11: When a poll and a request are both waiting, the poll is issued first and the request follows when the poll's transaction ends.
- R12: Reply bytes beyond 16 are dropped. `reply_len` stays 16 and `overflow` is set until the next transaction starts.
- R13: `rd_data` presents the buffered reply byte at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request slot free |
| req_cmd | input | 8 | Command byte |
| req_data | input | MAXD*8 | Data bytes, byte 0 in bits 7:0 |
| req_nd | input | $clog2(MAXD+1) | Number of data bytes |
| req_rx | input | 1 | Reply expected |
| poll_kick | input | 1 | Queue a poll |
| srq | input | 1 | Service request seen |
| ap_mask | input | NDEV | Autopoll device mask |
| xc_shift_done | input | 1 | Byte shift complete pulse |
| xc_rx | input | 8 | Byte shifted in |
| xc_attn_n | input | 1 | Controller attention, active low |
| xc_phase | output | 2 | Phase code to transceiver |
| xc_dir_out | output | 1 | Shift direction, 1 = output |
| xc_tx | output | 8 | Byte to shift out |
| rd_addr | input | $clog2(RDEPTH) | Reply buffer read address |
| rd_data | output | 8 | Reply buffer read data |
| done | output | 1 | Transaction end pulse |
| reply_len | output | $clog2(RDEPTH+1) | Reply byte count |
| overflow | output | 1 | Reply exceeded buffer |
| last_cmd | output | 8 | Last accepted command |
| last_talk | output | 8 | Last accepted Talk |
| last_poll | output | 8 | Last accepted Talk register 0 |

## Verification
The bench pre-empts a command with attention. A design that recorded the aborted command, or dropped it instead of retrying, would show the wrong `last_cmd` or never re-issue the byte. The poll sequence covers three cases:

- reuse of the current address;
- an advance triggered by `srq`;
- a wrap from 9 back to 3 and a jump when the mask loses the current address.

A selector without wrap or without the mask test picks the wrong command. An 18-byte packet checks that the count saturates at 16 and the flag rises, where a careless buffer would wrap and overwrite byte 0. A poll kick with an empty mask, and a poll and a request queued in the same cycle, expose wrong ordering or a spurious start.

// File: rtl/sbh_pkg.sv
package sbh_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'b00,
    PH_EVEN = 2'b01,
    PH_ODD  = 2'b10,
    PH_IDLE = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SEND,
    S_READ
  } ctl_e;

  localparam logic [1:0] OP_TALK = 2'b11;

  function automatic logic is_talk(input logic [7:0] c);
    return c[3:2] == OP_TALK;
  endfunction
endpackage

// File: rtl/sbh_poll_sel.sv
module sbh_poll_sel #(
  parameter int NDEV = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDEV-1:0] mask,
  input  logic [7:0]      last_cmd,
  input  logic [7:0]      last_poll,
  input  logic            srq,
  output logic [7:0]      poll_cmd,
  output logic            any
);
  localparam int AW = $clog2(NDEV);

  logic [AW-1:0] cur, nxt, addr;
  logic          adv;

  assign cur = last_poll[7:4];

  always_comb begin
    logic [AW-1:0] j;
    logic          found;
    j     = '0;
    found = 1'b0;
    nxt   = cur;
    for (int k = 1; k <= NDEV; k++) begin
      j = AW'((int'(cur) + k) % NDEV);
      if (!found && mask[j]) begin
        nxt   = j;
        found = 1'b1;
      end
    end
  end

  assign adv      = (srq && last_cmd == last_poll) || !mask[cur];
  assign addr     = adv ? nxt : cur;
  assign poll_cmd = {addr, 4'b1100};
  assign any      = |mask;

  // R9: a chosen poll address is always present in a non-empty mask
  a_r9_addr_in_mask: assert property (@(posedge clk) disable iff (rst)
    any |-> mask[addr]);
endmodule

// File: rtl/sbh_rbuf.sv
module sbh_rbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbh_seq.sv
module sbh_seq
  import sbh_pkg::*;
#(
  parameter int MAXD   = 8,
  parameter int RDEPTH = 16,
  parameter int NDEV   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [7:0]                  req_cmd,
  input  logic [MAXD*8-1:0]           req_data,
  input  logic [$clog2(MAXD+1)-1:0]   req_nd,
  input  logic                        req_rx,
  input  logic                        poll_kick,
  input  logic                        srq,
  input  logic [NDEV-1:0]             ap_mask,
  input  logic                        xc_shift_done,
  input  logic [7:0]                  xc_rx,
  input  logic                        xc_attn_n,
  output logic [1:0]                  xc_phase,
  output logic                        xc_dir_out,
  output logic [7:0]                  xc_tx,
  input  logic [$clog2(RDEPTH)-1:0]   rd_addr,
  output logic [7:0]                  rd_data,
  output logic                        done,
  output logic [$clog2(RDEPTH+1)-1:0] reply_len,
  output logic                        overflow,
  output logic [7:0]                  last_cmd,
  output logic [7:0]                  last_talk,
  output logic [7:0]                  last_poll
);
  localparam int NDW = $clog2(MAXD + 1);
  localparam int LW  = $clog2(RDEPTH + 1);
  localparam int RAW = $clog2(RDEPTH);

  ctl_e              state;
  phase_e            phase;
  logic              held_v, h_rx, poll_pend, cur_poll, c_acc;
  logic [7:0]        h_cmd, c_cmd;
  logic [MAXD*8-1:0] h_data;
  logic [NDW-1:0]    h_nd, idx, cur_nd;
  logic              cur_rx;
  logic [LW-1:0]     len;
  logic [7:0]        poll_cmd;
  logic              poll_any;
  logic              we;
  logic [RAW-1:0]    waddr;

  sbh_poll_sel #(.NDEV(NDEV)) u_sel (
    .clk(clk), .rst(rst), .mask(ap_mask), .last_cmd(last_cmd),
    .last_poll(last_poll), .srq(srq), .poll_cmd(poll_cmd), .any(poll_any)
  );

  always_comb begin
    we    = 1'b0;
    waddr = '0;
    if (xc_shift_done && !xc_attn_n) begin
      if (state == S_IDLE) we = 1'b1;
      else if (state == S_READ && len < LW'(RDEPTH)) begin
        we    = 1'b1;
        waddr = len[RAW-1:0];
      end
    end
  end

  sbh_rbuf #(.DEPTH(RDEPTH), .W(8)) u_buf (
    .clk(clk), .we(we), .waddr(waddr), .wdata(xc_rx),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign cur_nd    = cur_poll ? '0 : h_nd;
  assign cur_rx    = cur_poll ? 1'b1 : h_rx;
  assign req_ready = !held_v;
  assign xc_phase  = phase;
  assign reply_len = len;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      phase      <= PH_IDLE;
      xc_dir_out <= 1'b0;
      xc_tx      <= '0;
      held_v     <= 1'b0;
      h_cmd      <= '0;
      h_data     <= '0;
      h_nd       <= '0;
      h_rx       <= 1'b0;
      poll_pend  <= 1'b0;
      cur_poll   <= 1'b0;
      c_acc      <= 1'b0;
      c_cmd      <= '0;
      idx        <= '0;
      len        <= '0;
      overflow   <= 1'b0;
      done       <= 1'b0;
      last_cmd   <= 8'h00;
      last_talk  <= 8'h0C;
      last_poll  <= 8'h0C;
    end else begin
      done <= 1'b0;
      if (req_valid && !held_v) begin
        held_v <= 1'b1;
        h_cmd  <= req_cmd;
        h_data <= req_data;
        h_nd   <= req_nd;
        h_rx   <= req_rx;
      end
      case (state)
        S_IDLE: begin
          if (xc_shift_done) begin
            overflow <= 1'b0;
            c_acc    <= 1'b0;
            if (!xc_attn_n) begin
              len   <= LW'(1);
              phase <= PH_EVEN;
              state <= S_READ;
            end else begin
              len  <= '0;
              done <= 1'b1;
            end
          end else if (poll_pend || held_v) begin
            cur_poll   <= poll_pend;
            c_cmd      <= poll_pend ? poll_cmd : h_cmd;
            xc_tx      <= poll_pend ? poll_cmd : h_cmd;
            xc_dir_out <= 1'b1;
            phase      <= PH_CMD;
            idx        <= '0;
            c_acc      <= 1'b0;
            overflow   <= 1'b0;
            len        <= '0;
            state      <= S_SEND;
          end
        end
        S_SEND: begin
          if (xc_shift_done) begin
            if (phase == PH_CMD && !xc_attn_n) begin
              state      <= S_READ;
              xc_dir_out <= 1'b0;
              phase      <= PH_EVEN;
            end else begin
              if (phase == PH_CMD) begin
                c_acc    <= 1'b1;
                last_cmd <= c_cmd;
                if (is_talk(c_cmd)) begin
                  last_talk <= c_cmd;
                  if (c_cmd[1:0] == 2'b00) last_poll <= c_cmd;
                end
              end
              if (idx < cur_nd) begin
                xc_tx <= h_data[int'(idx)*8 +: 8];
                idx   <= idx + 1'b1;
                phase <= (phase == PH_CMD) ? PH_EVEN : phase_e'(~phase);
              end else if (cur_rx) begin
                state      <= S_READ;
                xc_dir_out <= 1'b0;
                phase      <= (phase == PH_CMD) ? PH_EVEN : phase_e'(~phase);
              end else begin
                state      <= S_IDLE;
                xc_dir_out <= 1'b0;
                phase      <= PH_IDLE;
                done       <= 1'b1;
                if (cur_poll) poll_pend <= 1'b0;
                else          held_v    <= 1'b0;
              end
            end
          end
        end
        default: begin
          if (xc_shift_done) begin
            if (!xc_attn_n) begin
              if (len < LW'(RDEPTH)) len <= len + 1'b1;
              else                   overflow <= 1'b1;
              phase <= phase_e'(~phase);
            end else begin
              state <= S_IDLE;
              phase <= PH_IDLE;
              done  <= 1'b1;
              if (c_acc) begin
                if (cur_poll) poll_pend <= 1'b0;
                else          held_v    <= 1'b0;
              end
            end
          end
        end
      endcase
      if (poll_kick && poll_any) poll_pend <= 1'b1;
    end
  end

  // R2: the command phase is only ever entered from idle
  a_r2_cmd_from_idle: assert property (@(posedge clk) disable iff (rst)
    (xc_phase != 2'b00) |=> (xc_phase != 2'b00 || $past(xc_phase) == 2'b11));
  // R2: driving out always begins with a command byte
  a_r2_dir_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(xc_dir_out) |-> xc_phase == 2'b00);
  // R3 / R5: an end report coincides with idle phase and input direction
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (xc_phase == 2'b11 && !xc_dir_out));
  // R12: the count never passes the buffer size
  a_r12_len_bound: assert property (@(posedge clk) disable iff (rst)
    reply_len <= LW'(RDEPTH));
  // R12: the overflow flag implies a full buffer
  a_r12_ovf_full: assert property (@(posedge clk) disable iff (rst)
    overflow |-> reply_len == LW'(RDEPTH));
endmodule

// File: tb/sim_sbh_seq.sv
module sim_sbh_seq;
  localparam int CLK_NS = 10;
  localparam int MAXD   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_ready, req_rx = 1'b0;
  logic [7:0]        req_cmd = '0;
  logic [MAXD*8-1:0] req_data = '0;
  logic [3:0]        req_nd = '0;
  logic              poll_kick = 1'b0, srq = 1'b0;
  logic [15:0]       ap_mask = '0;
  logic              xc_shift_done = 1'b0, xc_attn_n = 1'b1;
  logic [7:0]        xc_rx = '0;
  logic [1:0]        xc_phase;
  logic              xc_dir_out;
  logic [7:0]        xc_tx;
  logic [3:0]        rd_addr = '0;
  logic [7:0]        rd_data;
  logic              done, overflow;
  logic [4:0]        reply_len;
  logic [7:0]        last_cmd, last_talk, last_poll;

  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  sbh_seq #(.MAXD(MAXD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_data(req_data), .req_nd(req_nd), .req_rx(req_rx),
    .poll_kick(poll_kick), .srq(srq), .ap_mask(ap_mask),
    .xc_shift_done(xc_shift_done), .xc_rx(xc_rx), .xc_attn_n(xc_attn_n),
    .xc_phase(xc_phase), .xc_dir_out(xc_dir_out), .xc_tx(xc_tx),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .reply_len(reply_len),
    .overflow(overflow), .last_cmd(last_cmd), .last_talk(last_talk),
    .last_poll(last_poll)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input logic attn_n);
    @(negedge clk);
    xc_shift_done = 1'b1; xc_rx = b; xc_attn_n = attn_n;
    @(negedge clk);
    xc_shift_done = 1'b0; xc_attn_n = 1'b1;
  endtask

  task automatic submit(input logic [7:0] c, input logic [63:0] d,
                        input logic [3:0] nd, input logic rx);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_data = d; req_nd = nd; req_rx = rx;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic kick();
    @(negedge clk); poll_kick = 1'b1;
    @(negedge clk); poll_kick = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk);
    chk("R13 reply byte", rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 phase", xc_phase, 2'b11);
    chk("R1 dir", xc_dir_out, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 last_cmd", last_cmd, 8'h00);
    chk("R1 last_talk", last_talk, 8'h0C);
    chk("R1 last_poll", last_poll, 8'h0C);
  endtask

  task automatic t_write();
    submit(8'h2B, 64'hB2A1, 4'd2, 1'b0);
    chk("R2 dir", xc_dir_out, 1); chk("R2 tx", xc_tx, 8'h2B); chk("R2 phase", xc_phase, 2'b00);
    chk("R2 busy", req_ready, 0);
    xfer(8'h00, 1'b1);
    chk("R4 phase even", xc_phase, 2'b01); chk("R4 byte0", xc_tx, 8'hA1);
    xfer(8'h00, 1'b1);
    chk("R4 phase odd", xc_phase, 2'b10); chk("R4 byte1", xc_tx, 8'hB2);
    xfer(8'h00, 1'b1);
    chk("R3 idle", xc_phase, 2'b11); chk("R3 done", done, 1); chk("R3 len", reply_len, 0);
    chk("R8 last_cmd", last_cmd, 8'h2B); chk("R8 talk kept", last_talk, 8'h0C);
  endtask

  task automatic t_noreply();
    submit(8'h61, 64'h0, 4'd0, 1'b0);
    xfer(8'h00, 1'b1);
    chk("R3 direct idle", xc_phase, 2'b11); chk("R3 done", done, 1);
  endtask

  task automatic t_talk();
    submit(8'h3C, 64'h0, 4'd0, 1'b1);
    xfer(8'h00, 1'b1);
    chk("R5 first phase", xc_phase, 2'b01); chk("R5 dir in", xc_dir_out, 0);
    xfer(8'h11, 1'b0); chk("R5 toggle odd", xc_phase, 2'b10);
    xfer(8'h22, 1'b0); chk("R5 toggle even", xc_phase, 2'b01);
    xfer(8'h33, 1'b0);
    xfer(8'hEE, 1'b1);
    chk("R5 done", done, 1); chk("R5 len", reply_len, 3); chk("R5 idle", xc_phase, 2'b11);
    chk("R8 last_cmd", last_cmd, 8'h3C); chk("R8 last_talk", last_talk, 8'h3C);
    chk("R8 last_poll", last_poll, 8'h3C);
    rd(4'd0, 8'h11); rd(4'd1, 8'h22); rd(4'd2, 8'h33);
  endtask

  task automatic t_unsol();
    xfer(8'h55, 1'b0);
    chk("R7 even", xc_phase, 2'b01);
    xfer(8'h66, 1'b0);
    xfer(8'h00, 1'b1);
    chk("R7 done", done, 1); chk("R7 len", reply_len, 2);
    rd(4'd0, 8'h55); rd(4'd1, 8'h66);
    xfer(8'h00, 1'b1);
    chk("R7 timeout done", done, 1); chk("R7 timeout len", reply_len, 0);
    chk("R7 timeout idle", xc_phase, 2'b11);
  endtask

  task automatic t_preempt();
    submit(8'h4D, 64'h0, 4'd0, 1'b1);
    chk("R6 cmd", xc_tx, 8'h4D);
    xfer(8'h00, 1'b0);
    chk("R6 dir in", xc_dir_out, 0); chk("R6 even", xc_phase, 2'b01);
    chk("R6 not recorded", last_cmd, 8'h3C);
    xfer(8'h77, 1'b0);
    xfer(8'h00, 1'b1);
    chk("R6 reply len", reply_len, 1);
    rd(4'd0, 8'h77);
    chk("R6 retry phase", xc_phase, 2'b00); chk("R6 retry tx", xc_tx, 8'h4D);
    xfer(8'h00, 1'b1);
    xfer(8'h88, 1'b0);
    xfer(8'h00, 1'b1);
    chk("R6 retry done len", reply_len, 1);
    chk("R8 last_talk", last_talk, 8'h4D); chk("R8 poll kept", last_poll, 8'h3C);
    chk("R6 ready again", req_ready, 1);
  endtask

  task automatic t_overflow();
    xfer(8'd1, 1'b0);
    for (int i = 2; i <= 18; i++) xfer(8'(i), 1'b0);
    xfer(8'h00, 1'b1);
    chk("R12 len", reply_len, 16); chk("R12 flag", overflow, 1);
    rd(4'd15, 8'd16); rd(4'd0, 8'd1);
  endtask

  task automatic run_poll(input logic [7:0] exp, input string tag);
    kick();
    chk(tag, xc_tx, exp);
    xfer(8'h00, 1'b1);
    xfer(8'h00, 1'b1);
    chk("R9 poll done", done, 1);
  endtask

  task automatic t_poll();
    ap_mask = 16'h0208; srq = 1'b1;
    run_poll(8'h3C, "R9 keep address");
    chk("R12 flag cleared", overflow, 0);
    run_poll(8'h9C, "R9 advance on srq");
    run_poll(8'h3C, "R9 wrap");
    ap_mask = 16'h0020; srq = 1'b0;
    run_poll(8'h5C, "R9 address left mask");
    chk("R8 last_poll", last_poll, 8'h5C);
  endtask

  task automatic t_empty();
    ap_mask = 16'h0000;
    kick();
    repeat (2) @(negedge clk);
    chk("R10 no start phase", xc_phase, 2'b11);
    chk("R10 no start dir", xc_dir_out, 0);
  endtask

  task automatic t_order();
    ap_mask = 16'h0020; srq = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 8'h6B; req_nd = 4'd0; req_rx = 1'b0; poll_kick = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; poll_kick = 1'b0;
    @(negedge clk);
    chk("R11 poll first", xc_tx, 8'h5C);
    xfer(8'h00, 1'b1);
    xfer(8'h00, 1'b1);
    @(negedge clk);
    chk("R11 request next", xc_tx, 8'h6B);
    chk("R11 request phase", xc_phase, 2'b00);
    xfer(8'h00, 1'b1);
    chk("R11 done", done, 1); chk("R11 recorded", last_cmd, 8'h6B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_noreply();
    t_talk();
    t_unsol();
    t_preempt();
    t_overflow();
    t_poll();
    t_empty();
    t_order();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule